// File: doc/BRIEF.md
# Byte-Stream Packer for a 16-bit Send Bus with Carry-Over Byte

This block turns a byte-addressed move into a stream of 16-bit words on a send bus. A move command gives a start byte address at any alignment, a byte count, a chained flag and a direction qualifier. The block reads aligned 32-bit words from a memory read port, pulls out the byte lanes that belong to the move in address order, and packs each two consecutive bytes into one bus word. The earlier byte goes in the low half and the later byte in the high half.

A series of chained send moves behaves as one continuous byte stream. When a chained send move ends on an odd byte, that byte is not put on the bus. It is kept in an output latch and a carry flag is set. The next send move then opens with a word whose low half is the carried byte and whose high half is its own first byte. A non-chained move that ends on an odd byte sends that byte alone, with a single-byte qualifier. A move that is not in the send direction never touches the carried byte.

Top module: `wide_byte_packer`

## Requirements
- R1: Memory reads present the word address with its two low bits zero. The request stays high with a stable address until `mem_valid` is seen. The byte at address n is taken from bits [8*(n mod 4)+7 : 8*(n mod 4)] of the returned word.
- R2: Each bus word holds two consecutive stream bytes: the earlier one in bits [7:0] and the later one in bits [15:8], with `bus_single` low.
- R3: A chained send move (`cmd_chain`=1, `cmd_send`=1) that ends with an unpaired byte does not put that byte on the bus. It stores the byte in `hold_byte` and sets `hold_flag`.
- R4: A move with `cmd_chain`=0 never sets `hold_flag`. If it ends on an unpaired byte, it sends a word with that byte in bits [7:0], bits [15:8] zero and `bus_single`=1.
- R5: A move with `cmd_send`=0 never sets `hold_flag`. It leaves `hold_byte` and `hold_flag` unchanged and does not use the carried byte. An unpaired last byte is sent as in R4.
- R6: When `hold_flag` is set as a send move with a nonzero count is accepted, the first bus word of that move carries `hold_byte` in bits [7:0] and the move's first byte in bits [15:8].
- R7: `hold_flag` clears in the cycle after the bus accepts the word that carries the held byte, unless that same move carries a new byte over.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_data` and `bus_single` hold their values. No byte is lost or repeated under backpressure.
- R9: A command with a count of zero raises `move_done` in the next cycle and leaves `hold_byte` and `hold_flag` unchanged.
- R10: `move_done` pulses one cycle after the last word of a move is accepted or its last byte is latched. `cmd_ready` is low while a move with a nonzero count is in progress and while `bus_valid` is high. After reset, `cmd_ready` is high and the flag, the bus and the memory request are idle.
- R11: A chained send of 5 bytes from 0x03 sends 0x0403 and 0x0605 and holds 0x07. A following chained send of 5 bytes from 0x09 sends 0x0907, 0x0B0A and 0x0D0C and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Move command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_addr | input | AW | Start byte address |
| cmd_count | input | CW | Byte count |
| cmd_chain | input | 1 | Move is chained to the next one |
| cmd_send | input | 1 | Move is in the send direction |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Aligned word byte address |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | 8*MEM_BYTES | Read word, little-endian lanes |
| bus_valid | output | 1 | Bus word present |
| bus_ready | input | 1 | Bus takes the word |
| bus_data | output | 16 | Bus word |
| bus_single | output | 1 | Only bits [7:0] carry data |
| hold_flag | output | 1 | A carried byte is held |
| hold_byte | output | 8 | Carried byte latch |
| move_done | output | 1 | Move-complete pulse |

## Verification
The bench targets the carry-over chain. It runs a chained odd move followed by a send move, and places a non-send move and a zero-count move between the two. A design that pairs the carried byte wrongly would put the new move's first byte in the low half. A design that lets a non-send move use the carried byte or clear the flag would lose 0x33 from the following word. A design that sets the flag on a normal move would hold back a byte that should have gone out as a single-byte word. Starts at every byte alignment and random bus stalls expose lane-select errors, words that change while stalled, and bytes that are dropped or repeated at word boundaries. A done pulse that fires before the last word leaves the reference queue non-empty and is reported.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
    localparam int BUS_BYTES = 2;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_HAVE = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/wbp_lane_pick.sv
module wbp_lane_pick #(
    parameter int MEM_BYTES = 4,
    localparam int LB = $clog2(MEM_BYTES)
) (
    input  logic [8*MEM_BYTES-1:0] word,
    input  logic [LB-1:0]          lane,
    output logic [7:0]             sel
);
    logic [7:0] lanes [MEM_BYTES];

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign sel = lanes[lane];
endmodule

// File: rtl/wbp_fetch.sv
module wbp_fetch
    import wbp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CW        = 12,
    parameter int MEM_BYTES = 4,
    localparam int LB = $clog2(MEM_BYTES),
    localparam int MW = 8 * MEM_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] start_count,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [MW-1:0] mem_rdata,
    output logic          byte_valid,
    output logic [7:0]    byte_data,
    output logic          byte_last,
    input  logic          byte_take
);
    typedef struct packed {
        fetch_state_e  st;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
        logic [MW-1:0] word;
    } fetch_regs_t;

    fetch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            F_IDLE: begin
                if (start) begin
                    r_d.st   = F_REQ;
                    r_d.addr = start_addr;
                    r_d.left = start_count;
                end
            end
            F_REQ: begin
                if (mem_valid) begin
                    r_d.word = mem_rdata;
                    r_d.st   = F_HAVE;
                end
            end
            F_HAVE: begin
                if (byte_take) begin
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == CW'(1))
                        r_d.st = F_IDLE;
                    else if (&r_q.addr[LB-1:0])
                        r_d.st = F_REQ;
                end
            end
            default: r_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    wbp_lane_pick #(.MEM_BYTES(MEM_BYTES)) u_pick (
        .word (r_q.word),
        .lane (r_q.addr[LB-1:0]),
        .sel  (byte_data)
    );

    assign busy       = (r_q.st != F_IDLE);
    assign mem_req    = (r_q.st == F_REQ);
    assign mem_addr   = {r_q.addr[AW-1:LB], {LB{1'b0}}};
    assign byte_valid = (r_q.st == F_HAVE);
    assign byte_last  = (r_q.left == CW'(1));
endmodule

// File: rtl/wbp_pair.sv
module wbp_pair
    import wbp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   start_chain,
    input  logic                   start_send,
    input  logic                   zero_move,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_data,
    input  logic                   byte_last,
    output logic                   byte_take,
    output logic                   bus_valid,
    input  logic                   bus_ready,
    output logic [8*BUS_BYTES-1:0] bus_data,
    output logic                   bus_single,
    output logic                   hold_flag,
    output logic [7:0]             hold_byte,
    output logic                   move_done
);
    typedef struct packed {
        logic                   chain;
        logic                   send;
        logic [7:0]             lo;
        logic                   lo_have;
        logic                   lo_held;
        logic                   ov;
        logic [8*BUS_BYTES-1:0] od;
        logic                   osingle;
        logic                   oheld;
        logic                   olast;
        logic [7:0]             hold;
        logic                   flag;
        logic                   done;
    } pair_regs_t;

    pair_regs_t p_d, p_q;
    logic       accept_w;

    assign byte_take = byte_valid && !p_q.ov;
    assign accept_w  = p_q.ov && bus_ready;

    always_comb begin
        p_d      = p_q;
        p_d.done = 1'b0;

        if (accept_w) begin
            p_d.ov = 1'b0;
            if (p_q.oheld) p_d.flag = 1'b0;
            if (p_q.olast) p_d.done = 1'b1;
        end

        if (zero_move) p_d.done = 1'b1;

        if (start) begin
            p_d.chain = start_chain;
            p_d.send  = start_send;
            if (start_send && p_q.flag) begin
                p_d.lo      = p_q.hold;
                p_d.lo_have = 1'b1;
                p_d.lo_held = 1'b1;
            end else begin
                p_d.lo_have = 1'b0;
                p_d.lo_held = 1'b0;
            end
        end

        if (byte_take) begin
            if (p_q.lo_have) begin
                p_d.ov      = 1'b1;
                p_d.od      = {byte_data, p_q.lo};
                p_d.osingle = 1'b0;
                p_d.oheld   = p_q.lo_held;
                p_d.olast   = byte_last;
                p_d.lo_have = 1'b0;
                p_d.lo_held = 1'b0;
            end else if (byte_last) begin
                if (p_q.chain && p_q.send) begin
                    p_d.hold = byte_data;
                    p_d.flag = 1'b1;
                    p_d.done = 1'b1;
                end else begin
                    p_d.ov      = 1'b1;
                    p_d.od      = {8'h00, byte_data};
                    p_d.osingle = 1'b1;
                    p_d.oheld   = 1'b0;
                    p_d.olast   = 1'b1;
                end
            end else begin
                p_d.lo      = byte_data;
                p_d.lo_have = 1'b1;
                p_d.lo_held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_valid  = p_q.ov;
    assign bus_data   = p_q.od;
    assign bus_single = p_q.osingle;
    assign hold_flag  = p_q.flag;
    assign hold_byte  = p_q.hold;
    assign move_done  = p_q.done;
endmodule

// File: rtl/wide_byte_packer.sv
module wide_byte_packer #(
    parameter int AW        = 16,
    parameter int CW        = 12,
    parameter int MEM_BYTES = 4,
    localparam int MW = 8 * MEM_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_chain,
    input  logic          cmd_send,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [MW-1:0] mem_rdata,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [15:0]   bus_data,
    output logic          bus_single,
    output logic          hold_flag,
    output logic [7:0]    hold_byte,
    output logic          move_done
);
    logic       fetch_busy;
    logic       accept_cmd;
    logic       start_move;
    logic       zero_move;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_last;
    logic       byte_take;

    assign cmd_ready  = !fetch_busy && !bus_valid;
    assign accept_cmd = cmd_valid && cmd_ready;
    assign start_move = accept_cmd && (cmd_count != '0);
    assign zero_move  = accept_cmd && (cmd_count == '0);

    wbp_fetch #(.AW(AW), .CW(CW), .MEM_BYTES(MEM_BYTES)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_move),
        .start_addr  (cmd_addr),
        .start_count (cmd_count),
        .busy        (fetch_busy),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_valid   (mem_valid),
        .mem_rdata   (mem_rdata),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_last   (byte_last),
        .byte_take   (byte_take)
    );

    wbp_pair u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_move),
        .start_chain (cmd_chain),
        .start_send  (cmd_send),
        .zero_move   (zero_move),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_last   (byte_last),
        .byte_take   (byte_take),
        .bus_valid   (bus_valid),
        .bus_ready   (bus_ready),
        .bus_data    (bus_data),
        .bus_single  (bus_single),
        .hold_flag   (hold_flag),
        .hold_byte   (hold_byte),
        .move_done   (move_done)
    );
endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
    parameter int AW        = 16,
    parameter int CW        = 12,
    parameter int MEM_BYTES = 4,
    localparam int LB = $clog2(MEM_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [CW-1:0] cmd_count,
    input logic          cmd_chain,
    input logic          cmd_send,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_valid,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic [15:0]   bus_data,
    input logic          bus_single,
    input logic          hold_flag,
    input logic [7:0]    hold_byte,
    input logic          move_done
);
    logic mv_chain_q, mv_send_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_chain_q <= 1'b0;
            mv_send_q  <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            mv_chain_q <= cmd_chain;
            mv_send_q  <= cmd_send;
        end
    end

    assert_req_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LB-1:0] == '0));

    assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    assert_flag_needs_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_flag) |-> mv_chain_q);

    assert_flag_needs_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_flag) |-> mv_send_q);

    assert_single_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_single) |-> (bus_data[15:8] == 8'h00));

    assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_single)));

    assert_zero_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_count == '0) |=>
            (move_done && $stable(hold_flag) && $stable(hold_byte)));

    assert_no_cmd_while_sending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !cmd_ready);
endmodule

bind wide_byte_packer wbp_checker #(.AW(AW), .CW(CW), .MEM_BYTES(MEM_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_count  (cmd_count),
    .cmd_chain  (cmd_chain),
    .cmd_send   (cmd_send),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_data   (bus_data),
    .bus_single (bus_single),
    .hold_flag  (hold_flag),
    .hold_byte  (hold_byte),
    .move_done  (move_done)
);

// File: tb/wide_byte_packer_test.sv
module wide_byte_packer_test;
    localparam int AW = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          cmd_chain = 1'b0;
    logic          cmd_send = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          bus_valid;
    logic          bus_ready = 1'b0;
    logic [15:0]   bus_data;
    logic          bus_single;
    logic          hold_flag;
    logic [7:0]    hold_byte;
    logic          move_done;

    always #4 clk = ~clk;

    wide_byte_packer #(.AW(AW), .CW(CW), .MEM_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .cmd_chain(cmd_chain), .cmd_send(cmd_send),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_data(bus_data), .bus_single(bus_single),
        .hold_flag(hold_flag), .hold_byte(hold_byte), .move_done(move_done)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [15:0] exp_d[$];
    bit          exp_s[$];
    string       exp_t[$];
    bit          mflag = 0;
    logic [7:0]  mhold = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return a[7:0] ^ {4'h0, a[11:8]};
    endfunction

    // memory responder
    int mdelay = 1;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid = 1'b0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
        end else if (mem_req) begin
            if (mdelay == 0) begin
                chk(mem_addr[1:0] == 2'b00, "R1", "word address alignment", mem_addr[1:0], 0);
                mem_rdata = {mb(mem_addr + 16'd3), mb(mem_addr + 16'd2),
                             mb(mem_addr + 16'd1), mb(mem_addr)};
                mem_valid = 1'b1;
                mdelay = $urandom % 3;
            end else begin
                mdelay--;
            end
        end
    end

    // bus sink and word comparison
    bit          prev_stall = 0;
    logic [15:0] prev_d = '0;
    bit          prev_s = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bus_ready = ($urandom % 4) != 0;
            if (prev_stall)
                chk(bus_valid && bus_data == prev_d && bus_single == prev_s, "R8",
                    "word held under stall", bus_data, prev_d);
            prev_stall = bus_valid && !bus_ready;
            prev_d = bus_data;
            prev_s = bus_single;
            if (bus_valid && bus_ready) begin
                if (exp_d.size() == 0) begin
                    chk(0, "R2", "unexpected bus word", bus_data, 0);
                end else begin
                    chk(bus_data == exp_d[0], exp_t[0], "bus word", bus_data, exp_d[0]);
                    chk(bus_single == exp_s[0], exp_t[0], "single qualifier", bus_single, exp_s[0]);
                    void'(exp_d.pop_front());
                    void'(exp_s.pop_front());
                    void'(exp_t.pop_front());
                end
            end
        end
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "R10", "watchdog expired", cycles, 0);
            summary_and_end();
        end
    end

    // reference model: expected words and carry state for one move
    task automatic model_move(input int addr, input int cnt, input bit chain,
                              input bit send, input string tag);
        bit         have = 0;
        bit         used = 0;
        logic [7:0] lo = '0;
        logic [7:0] b;
        if (cnt > 0 && send && mflag) begin
            lo = mhold; have = 1; used = 1;
        end
        for (int i = 0; i < cnt; i++) begin
            b = mb(AW'(addr + i));
            if (have) begin
                exp_d.push_back({b, lo}); exp_s.push_back(0); exp_t.push_back(tag);
                have = 0;
            end else begin
                lo = b; have = 1;
            end
        end
        if (cnt > 0) begin
            if (used) mflag = 0;
            if (have) begin
                if (chain && send) begin
                    mhold = lo; mflag = 1;
                end else begin
                    exp_d.push_back({8'h00, lo}); exp_s.push_back(1); exp_t.push_back(tag);
                end
            end
        end
    endtask

    task automatic do_move(input int addr, input int cnt, input bit chain,
                           input bit send, input string tag);
        int wait_n = 0;
        model_move(addr, cnt, chain, send, tag);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_addr = AW'(addr); cmd_count = CW'(cnt);
        cmd_chain = chain; cmd_send = send; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (cnt == 0) begin
            chk(move_done == 1'b1, "R9", "zero move done next cycle", move_done, 1);
        end else begin
            chk(cmd_ready == 1'b0, "R10", "ready low during move", cmd_ready, 0);
            while (!move_done && wait_n < 2000) begin
                @(negedge clk);
                wait_n++;
            end
        end
        chk(exp_d.size() == 0, "R10", "all words out at done", exp_d.size(), 0);
        chk(hold_flag == mflag, tag, "carry flag after move", hold_flag, mflag);
        if (mflag)
            chk(hold_byte == mhold, tag, "carried byte", hold_byte, mhold);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10", "reset cmd_ready", cmd_ready, 1);
        chk(bus_valid == 1'b0, "R10", "reset bus_valid", bus_valid, 0);
        chk(mem_req == 1'b0, "R10", "reset mem_req", mem_req, 0);
        chk(hold_flag == 1'b0, "R10", "reset hold_flag", hold_flag, 0);
        chk(move_done == 1'b0, "R10", "reset move_done", move_done, 0);

        // R11 worked example
        do_move(16'h03, 5, 1, 1, "R11");
        chk(hold_byte == 8'h07, "R11", "held byte 0x07", hold_byte, 8'h07);
        do_move(16'h09, 5, 1, 1, "R11");
        chk(hold_flag == 1'b0, "R7", "flag cleared after use", hold_flag, 0);

        // R4 normal move with odd tail
        do_move(16'h20, 3, 0, 1, "R4");
        // R3 carry, R5 non-send move keeps it, R6 carry paired afterwards
        do_move(16'h31, 3, 1, 1, "R3");
        do_move(16'h40, 3, 1, 0, "R5");
        chk(hold_flag && hold_byte == 8'h33, "R5", "carry kept over non-send move",
            {hold_flag, hold_byte}, 9'h133);
        do_move(16'h50, 2, 0, 1, "R6");
        do_move(16'h62, 1, 1, 0, "R5");
        // R9 zero count with a carried byte
        do_move(16'h70, 1, 1, 1, "R3");
        do_move(16'h90, 0, 1, 1, "R9");
        do_move(16'h81, 1, 1, 1, "R6");
        // all start alignments, R1/R2
        for (int a = 0; a < 4; a++) do_move(16'h100 + a, 7, 0, 1, "R1");
        // random mix, R2 and R8
        for (int k = 0; k < 60; k++)
            do_move($urandom % 1024, $urandom % 13, 1'($urandom), 1'($urandom), "R2");
        repeat (4) @(negedge clk);
        summary_and_end();
    end
endmodule